// File: doc/BRIEF.md
# Pipelined Load Address and Data Unit

This block carries out predicated loads of bytes, halfwords and words, each in a signed or an unsigned form. In the issue cycle it takes a base value and an offset. The offset is either a 5-bit constant from the instruction or a value read from an offset register. The block forms the access address and the updated base, checks alignment and drives a read request into a simple synchronous memory. The memory returns a 32-bit word one cycle after the request. The block then selects the addressed lane, extends it to 32 bits and hands the result back to the register file with its own destination index.

The base update leaves the unit one clock edge after issue, so the next operation can already use the new base. The loaded value leaves four edges later. A new load may be issued every cycle with no stalls, and up to four loads are in flight at once, each carrying its own tag. When the predicate is false, the issued operation does nothing.

Top module: `ld_pipe_unit`

## Requirements
- R1: With `iss_scaled`=1, the offset is shifted left by 2 for a word, by 1 for a halfword and by 0 for a byte before it is added. `iss_size` encodes byte as 0, halfword as 1 and word as 2.
- R2: With `iss_scaled`=0, the offset counts in bytes. A word load with constant 12 adds 12, where the scaled form adds 48.
- R3: With `iss_use_reg`=1, the offset is taken from `iss_offr` instead of the 5-bit constant `iss_imm`.
- R4: With `iss_off_given`=0, the offset is 1 for the increment and decrement modes and 0 for the plain mode. The result is then scaled like any other offset.
- R5: `iss_mode` selects the addressing mode:
  - 0: plain add. The address is base plus offset, and the base is not written.
  - 1: pre-increment. The access and the written base both use base plus offset.
  - 2: pre-decrement. The access and the written base both use base minus offset.
  - 3: post-increment. The access uses the old base, and the base is written as base plus offset.
  - 4: post-decrement. The access uses the old base, and the base is written as base minus offset.
- R6: `base_we`, `base_idx` and `base_val` are valid in the cycle after the issuing clock edge, together with `mem_re` and `mem_addr`.
- R7: `dst_we`, `dst_idx` and `dst_val` appear exactly four cycles after the matching `mem_re`. They are low in every cycle before that.
- R8: An issue with `iss_pred`=0 produces no memory read, no base write, no error flag and no destination write.
- R9: A misaligned access raises `misalign` for one cycle and produces no read and no destination write. A word is misaligned when address bits [1:0] are not zero, and a halfword when bit 0 is set. The base write of a modifying mode still happens.
- R10: Lanes are chosen little-endian from address bits [1:0]. Signed byte and halfword loads sign-extend, and unsigned loads zero-extend.
- R11: Loads issued on consecutive cycles each return their own data to their own destination index, one result per cycle.
- R12: After a synchronous reset, `mem_re`, `base_we`, `misalign` and `dst_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | A load is issued this cycle |
| iss_pred | input | 1 | Predicate condition of the issued load |
| iss_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| iss_signed | input | 1 | 1 for sign extension, 0 for zero extension |
| iss_mode | input | 3 | Addressing mode (see R5) |
| iss_use_reg | input | 1 | Take the offset from the offset register |
| iss_off_given | input | 1 | An explicit offset is present |
| iss_scaled | input | 1 | Scale the offset by access size |
| iss_imm | input | 5 | Unsigned constant offset |
| iss_base | input | AW | Base register value |
| iss_offr | input | AW | Offset register value |
| iss_base_idx | input | RI | Index of the base register |
| iss_dst | input | RI | Index of the destination register |
| mem_re | output | 1 | Memory read request |
| mem_addr | output | AW | Byte address of the read |
| mem_rdata | input | 32 | Read word, valid one cycle after `mem_re` |
| base_we | output | 1 | Base register write enable |
| base_idx | output | RI | Base register index to write |
| base_val | output | AW | Updated base value |
| misalign | output | 1 | One-cycle alignment error flag |
| dst_we | output | 1 | Destination write enable |
| dst_idx | output | RI | Destination register index |
| dst_val | output | 32 | Loaded and extended value |

## Verification
A wrong address or base computation shows up at `mem_addr` and `base_val` in the first cycle after issue. A wrong alignment decision or predicate gate shows up at the same time as a stray or missing `mem_re` or `misalign`. A tag that slips or gets corrupted on its way down the pipeline only becomes visible four cycles later: `dst_we` fires in the wrong cycle, or `dst_idx` or `dst_val` is wrong. Back-to-back issue catches a tag that drifts into a neighbouring slot. The lane and extension logic is probed with the same stored word read at every offset and in both signed and unsigned forms.

// File: rtl/ldu_pkg.sv
package ldu_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } ld_size_e;

  typedef enum logic [2:0] {
    AM_PLAIN   = 3'd0,
    AM_PREINC  = 3'd1,
    AM_PREDEC  = 3'd2,
    AM_POSTINC = 3'd3,
    AM_POSTDEC = 3'd4
  } ld_mode_e;
endpackage

// File: rtl/ldu_addr_gen.sv
module ldu_addr_gen
  import ldu_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] offr,
  input  logic [4:0]    imm,
  input  logic [1:0]    size,
  input  logic [2:0]    mode,
  input  logic          use_reg,
  input  logic          off_given,
  input  logic          scaled,
  output logic [AW-1:0] acc_addr,
  output logic [AW-1:0] new_base,
  output logic          wb,
  output logic          misal
);
  logic [AW-1:0] raw, step;
  logic [1:0]    shamt;
  logic          dec, post;

  always_comb begin
    // offset source, with a unit default for the stepping modes
    if (!off_given)
      raw = (mode == AM_PLAIN) ? '0 : AW'(1);
    else if (use_reg)
      raw = offr;
    else
      raw = AW'(imm);

    case (size)
      SZ_BYTE: shamt = 2'd0;
      SZ_HALF: shamt = 2'd1;
      default: shamt = 2'd2;
    endcase
    step = scaled ? (raw << shamt) : raw;

    dec  = (mode == AM_PREDEC)  || (mode == AM_POSTDEC);
    post = (mode == AM_POSTINC) || (mode == AM_POSTDEC);
    wb   = (mode == AM_PREINC) || (mode == AM_PREDEC) || post;

    new_base = dec ? (base - step) : (base + step);
    acc_addr = post ? base : new_base;

    case (size)
      SZ_BYTE: misal = 1'b0;
      SZ_HALF: misal = acc_addr[0];
      default: misal = |acc_addr[1:0];
    endcase
  end
endmodule

// File: rtl/ldu_extract.sv
module ldu_extract
  import ldu_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [1:0]        lane,
  input  logic [1:0]        size,
  input  logic              sgn,
  output logic [WORD_W-1:0] val
);
  logic [7:0]  b;
  logic [15:0] h;

  always_comb begin
    case (lane)
      2'd0:    b = word[7:0];
      2'd1:    b = word[15:8];
      2'd2:    b = word[23:16];
      default: b = word[31:24];
    endcase
    h = lane[1] ? word[31:16] : word[15:0];

    case (size)
      SZ_BYTE: val = {{(WORD_W-8){sgn & b[7]}}, b};
      SZ_HALF: val = {{(WORD_W-16){sgn & h[15]}}, h};
      default: val = word;
    endcase
  end
endmodule

// File: rtl/ld_pipe_unit.sv
module ld_pipe_unit
  import ldu_pkg::*;
#(
  parameter int AW = 32,
  parameter int RI = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic              iss_pred,
  input  logic [1:0]        iss_size,
  input  logic              iss_signed,
  input  logic [2:0]        iss_mode,
  input  logic              iss_use_reg,
  input  logic              iss_off_given,
  input  logic              iss_scaled,
  input  logic [4:0]        iss_imm,
  input  logic [AW-1:0]     iss_base,
  input  logic [AW-1:0]     iss_offr,
  input  logic [RI-1:0]     iss_base_idx,
  input  logic [RI-1:0]     iss_dst,
  output logic              mem_re,
  output logic [AW-1:0]     mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              base_we,
  output logic [RI-1:0]     base_idx,
  output logic [AW-1:0]     base_val,
  output logic              misalign,
  output logic              dst_we,
  output logic [RI-1:0]     dst_idx,
  output logic [WORD_W-1:0] dst_val
);
  // stages E1..E3 carry a tag; E3 also holds the returned word
  localparam int TAG_STAGES = 3;

  typedef struct packed {
    logic          v;
    logic [RI-1:0] dst;
    logic [1:0]    size;
    logic          sgn;
    logic [1:0]    lane;
  } tag_t;

  logic [AW-1:0] acc_addr, new_base;
  logic          wb, misal, go;

  ldu_addr_gen #(.AW(AW)) u_agen (
    .base     (iss_base),
    .offr     (iss_offr),
    .imm      (iss_imm),
    .size     (iss_size),
    .mode     (iss_mode),
    .use_reg  (iss_use_reg),
    .off_given(iss_off_given),
    .scaled   (iss_scaled),
    .acc_addr (acc_addr),
    .new_base (new_base),
    .wb       (wb),
    .misal    (misal)
  );

  assign go = iss_valid & iss_pred;

  tag_t              tg [TAG_STAGES];
  logic [WORD_W-1:0] rdata_q;
  logic              e4_v;
  logic [RI-1:0]     e4_dst;
  logic [WORD_W-1:0] e4_val, ext_val;

  // E1: address, base update, alignment, read request
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_re   <= 1'b0;
      base_we  <= 1'b0;
      misalign <= 1'b0;
      mem_addr <= '0;
      base_idx <= '0;
      base_val <= '0;
      tg[0]    <= '0;
    end else begin
      mem_re   <= go & ~misal;
      mem_addr <= acc_addr;
      base_we  <= go & wb;
      base_idx <= iss_base_idx;
      base_val <= new_base;
      misalign <= go & misal;
      tg[0]    <= '{v: go & ~misal, dst: iss_dst, size: iss_size,
                    sgn: iss_signed, lane: acc_addr[1:0]};
    end
  end

  // E2..E3 tag shift; E3 captures the memory word
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 1; k < TAG_STAGES; k++) tg[k] <= '0;
    end else begin
      for (int k = 1; k < TAG_STAGES; k++) tg[k] <= tg[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (tg[TAG_STAGES-2].v) rdata_q <= mem_rdata;
  end

  ldu_extract u_ext (
    .word(rdata_q),
    .lane(tg[TAG_STAGES-1].lane),
    .size(tg[TAG_STAGES-1].size),
    .sgn (tg[TAG_STAGES-1].sgn),
    .val (ext_val)
  );

  // E4: extended value; E5: destination writeback
  always_ff @(posedge clk) begin
    if (rst) begin
      e4_v    <= 1'b0;
      e4_dst  <= '0;
      e4_val  <= '0;
      dst_we  <= 1'b0;
      dst_idx <= '0;
      dst_val <= '0;
    end else begin
      e4_v    <= tg[TAG_STAGES-1].v;
      e4_dst  <= tg[TAG_STAGES-1].dst;
      e4_val  <= ext_val;
      dst_we  <= e4_v;
      dst_idx <= e4_dst;
      dst_val <= e4_val;
    end
  end
endmodule

// File: rtl/ldu_checker.sv
module ldu_checker (
  input logic       clk,
  input logic       rst,
  input logic       iss_valid,
  input logic       iss_pred,
  input logic [1:0] iss_size,
  input logic [2:0] iss_mode,
  input logic       mem_re,
  input logic [1:0] mem_addr_lo,
  input logic       base_we,
  input logic       misalign,
  input logic       dst_we
);
  // R7: a destination write follows each read by exactly four cycles
  a_r7_dst_after_read: assert property (@(posedge clk) disable iff (rst)
    $past(mem_re, 4) |-> dst_we);
  a_r7_no_early_dst: assert property (@(posedge clk) disable iff (rst)
    dst_we |-> $past(mem_re, 4));

  // R8: a false predicate leaves no trace
  a_r8_pred_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(iss_valid && !iss_pred) |-> (!mem_re && !base_we && !misalign));

  // R5: the plain mode never writes the base
  a_r5_plain_no_wb: assert property (@(posedge clk) disable iff (rst)
    $past(iss_valid && iss_mode == 3'd0) |-> !base_we);

  // R6: a base write only follows a live issue
  a_r6_wb_from_issue: assert property (@(posedge clk) disable iff (rst)
    base_we |-> $past(iss_valid && iss_pred));

  // R9: errors suppress the read, and no read is misaligned
  a_r9_no_read_on_err: assert property (@(posedge clk) disable iff (rst)
    misalign |-> !mem_re);
  a_r9_word_aligned: assert property (@(posedge clk) disable iff (rst)
    (mem_re && $past(iss_size) == 2'd2) |-> (mem_addr_lo == 2'b00));
  a_r9_half_aligned: assert property (@(posedge clk) disable iff (rst)
    (mem_re && $past(iss_size) == 2'd1) |-> !mem_addr_lo[0]);
endmodule

bind ld_pipe_unit ldu_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .iss_valid  (iss_valid),
  .iss_pred   (iss_pred),
  .iss_size   (iss_size),
  .iss_mode   (iss_mode),
  .mem_re     (mem_re),
  .mem_addr_lo(mem_addr[1:0]),
  .base_we    (base_we),
  .misalign   (misalign),
  .dst_we     (dst_we)
);

// File: tb/tb_ld_pipe_unit.sv
module tb_ld_pipe_unit;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int RI = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          iss_valid = 0, iss_pred = 0, iss_signed = 0;
  logic [1:0]    iss_size = 0;
  logic [2:0]    iss_mode = 0;
  logic          iss_use_reg = 0, iss_off_given = 0, iss_scaled = 0;
  logic [4:0]    iss_imm = 0;
  logic [AW-1:0] iss_base = 0, iss_offr = 0;
  logic [RI-1:0] iss_base_idx = 0, iss_dst = 0;
  logic          mem_re, base_we, misalign, dst_we;
  logic [AW-1:0] mem_addr, base_val;
  logic [31:0]   mem_rdata = 0, dst_val;
  logic [RI-1:0] base_idx, dst_idx;

  int unsigned n_chk = 0, n_fail = 0;
  logic [31:0] mem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  ld_pipe_unit #(.AW(AW), .RI(RI)) dut (.*);

  // synchronous memory model: word returned one cycle after the request
  always @(posedge clk) if (mem_re) mem_rdata <= mem[mem_addr[9:2]];

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // issue one load and follow it through every stage
  task automatic run_load(input string req, input logic pred, input logic [1:0] sz,
      input logic sgn, input logic [2:0] mode, input logic ureg, input logic given,
      input logic scl, input logic [4:0] imm, input logic [31:0] base,
      input logic [31:0] offr, input logic [4:0] dst, input logic exp_rd,
      input logic [31:0] exp_addr, input logic exp_bwe, input logic [31:0] exp_bval,
      input logic exp_mis, input logic [31:0] exp_data);
    @(negedge clk);
    iss_valid = 1; iss_pred = pred; iss_size = sz; iss_signed = sgn;
    iss_mode = mode; iss_use_reg = ureg; iss_off_given = given; iss_scaled = scl;
    iss_imm = imm; iss_base = base; iss_offr = offr; iss_dst = dst; iss_base_idx = 5'd9;
    @(negedge clk);
    iss_valid = 0;
    chk(req, "mem_re", {31'b0, mem_re}, {31'b0, exp_rd});
    if (exp_rd) chk(req, "mem_addr", mem_addr, exp_addr);
    chk(req, "base_we", {31'b0, base_we}, {31'b0, exp_bwe});
    if (exp_bwe) begin
      chk(req, "base_val", base_val, exp_bval);
      chk(req, "base_idx", {27'b0, base_idx}, 32'd9);
    end
    chk(req, "misalign", {31'b0, misalign}, {31'b0, exp_mis});
    @(negedge clk);
    chk(req, "misalign_pulse", {31'b0, misalign}, 32'd0);
    repeat (2) @(negedge clk);
    chk("R7", "dst_we_early", {31'b0, dst_we}, 32'd0);
    @(negedge clk);
    chk(req, "dst_we", {31'b0, dst_we}, {31'b0, exp_rd});
    if (exp_rd) begin
      chk(req, "dst_val", dst_val, exp_data);
      chk(req, "dst_idx", {27'b0, dst_idx}, {27'b0, dst});
    end
  endtask

  task automatic t_reset;
    chk("R12", "mem_re", {31'b0, mem_re}, 0);
    chk("R12", "base_we", {31'b0, base_we}, 0);
    chk("R12", "misalign", {31'b0, misalign}, 0);
    chk("R12", "dst_we", {31'b0, dst_we}, 0);
  endtask

  task automatic t_plain_word;   // R6 R7: word from 0x100, base untouched
    run_load("R6", 1, 2'd2, 0, 3'd0, 0, 0, 0, 0, 32'h100, 0, 5'd1,
             1, 32'h100, 0, 0, 0, 32'h21F31996);
  endtask

  task automatic t_scaled;       // R1
    run_load("R1", 1, 2'd2, 0, 3'd0, 0, 1, 1, 5'd12, 32'h40, 0, 5'd2,
             1, 32'h70, 0, 0, 0, 32'h1CDF5A33);
    run_load("R1", 1, 2'd1, 1, 3'd0, 0, 1, 1, 5'd3, 32'h80, 0, 5'd3,
             1, 32'h86, 0, 0, 0, 32'h000021E2);
    run_load("R1", 1, 2'd0, 0, 3'd0, 0, 1, 1, 5'd5, 32'h80, 0, 5'd4,
             1, 32'h85, 0, 0, 0, 32'h0000005A);
  endtask

  task automatic t_unscaled;     // R2
    run_load("R2", 1, 2'd2, 0, 3'd0, 0, 1, 0, 5'd12, 32'h40, 0, 5'd5,
             1, 32'h4C, 0, 0, 0, 32'h13D05A2A);
  endtask

  task automatic t_reg_offset;   // R3 with pre-increment (R5)
    run_load("R3", 1, 2'd2, 0, 3'd1, 1, 1, 1, 5'd31, 32'h10, 32'h20, 5'd6,
             1, 32'h90, 1, 32'h90, 0, 32'h24E75A3B);
  endtask

  task automatic t_defaults;     // R4
    run_load("R4", 1, 2'd2, 0, 3'd2, 0, 0, 1, 5'd7, 32'h108, 0, 5'd7,
             1, 32'h104, 1, 32'h104, 0, 32'h41825A58);
    run_load("R4", 1, 2'd0, 0, 3'd3, 0, 0, 1, 5'd7, 32'h33, 0, 5'd8,
             1, 32'h33, 1, 32'h34, 0, 32'h0000000C);
  endtask

  task automatic t_post_dec;     // R5
    run_load("R5", 1, 2'd2, 0, 3'd4, 0, 1, 1, 5'd2, 32'h100, 0, 5'd10,
             1, 32'h100, 1, 32'hF8, 0, 32'h21F31996);
  endtask

  task automatic t_pred_false;   // R8
    run_load("R8", 0, 2'd2, 0, 3'd1, 0, 1, 1, 5'd4, 32'h100, 0, 5'd11,
             0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_misalign;     // R9
    run_load("R9", 1, 2'd2, 0, 3'd0, 0, 0, 0, 0, 32'h102, 0, 5'd12,
             0, 0, 0, 0, 1, 0);
    run_load("R9", 1, 2'd1, 0, 3'd3, 0, 0, 1, 0, 32'h101, 0, 5'd13,
             0, 0, 1, 32'h103, 1, 0);
  endtask

  task automatic t_extend;       // R10 on word 0x80FF7F01 at 0x180
    run_load("R10", 1, 2'd0, 1, 3'd0, 0, 0, 0, 0, 32'h183, 0, 5'd14,
             1, 32'h183, 0, 0, 0, 32'hFFFFFF80);
    run_load("R10", 1, 2'd0, 0, 3'd0, 0, 0, 0, 0, 32'h182, 0, 5'd15,
             1, 32'h182, 0, 0, 0, 32'h000000FF);
    run_load("R10", 1, 2'd0, 1, 3'd0, 0, 0, 0, 0, 32'h181, 0, 5'd16,
             1, 32'h181, 0, 0, 0, 32'h0000007F);
    run_load("R10", 1, 2'd1, 1, 3'd0, 0, 0, 0, 0, 32'h182, 0, 5'd17,
             1, 32'h182, 0, 0, 0, 32'hFFFF80FF);
    run_load("R10", 1, 2'd1, 0, 3'd0, 0, 0, 0, 0, 32'h182, 0, 5'd18,
             1, 32'h182, 0, 0, 0, 32'h000080FF);
    run_load("R10", 1, 2'd1, 0, 3'd0, 0, 0, 0, 0, 32'h180, 0, 5'd19,
             1, 32'h180, 0, 0, 0, 32'h00007F01);
  endtask

  task automatic t_back_to_back; // R11
    logic [31:0] addrs [4];
    logic [31:0] datas [4];
    addrs = '{32'h100, 32'h180, 32'h4C, 32'h70};
    datas = '{32'h21F31996, 32'h80FF7F01, 32'h13D05A2A, 32'h1CDF5A33};
    @(negedge clk);
    for (int c = 0; c <= 8; c++) begin
      if (c >= 5) begin
        chk("R11", "dst_we", {31'b0, dst_we}, 32'd1);
        chk("R11", "dst_idx", {27'b0, dst_idx}, 32'd20 + c - 5);
        chk("R11", "dst_val", dst_val, datas[c-5]);
      end
      if (c <= 3) begin
        iss_valid = 1; iss_pred = 1; iss_size = 2'd2; iss_signed = 0;
        iss_mode = 3'd0; iss_off_given = 0; iss_scaled = 0;
        iss_base = addrs[c]; iss_dst = 5'(20 + c);
      end else begin
        iss_valid = 0;
      end
      if (c < 8) @(negedge clk);
    end
    @(negedge clk);
    chk("R11", "dst_we_idle", {31'b0, dst_we}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++)
      mem[i] = {i[7:0], 8'hC3 ^ i[7:0], 8'h5A, i[7:0] + 8'h17};
    mem[64] = 32'h21F31996;
    mem[96] = 32'h80FF7F01;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_plain_word();
    t_scaled();
    t_unscaled();
    t_reg_offset();
    t_defaults();
    t_post_dec();
    t_pred_false();
    t_misalign();
    t_extend();
    t_back_to_back();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule